// File: doc/BRIEF.md
# Fuzzy Membership Grade Lookup

This block turns a crisp 8-bit sensor reading into the membership grade of that reading for one fuzzy adjective. The reading is latched on the falling clock edge. The latched value is then compared exactly against eleven programmed breakpoint values. A match raises one line of an eleven-line select bus. The raised line picks one row of a constant grade table, and that row is the grade output.

Breakpoints and grades are fixed parameters, so each adjective of a fuzzy controller gets its own instance with its own table. The breakpoints are sparse. A reading that equals no breakpoint raises no select line, and the grade is then zero. The select bus is a port of its own, so that the decoding can be observed apart from the table.

Top module: `fuzz_grade_lut`

## Requirements
- R1: `crisp_in` is latched only on the falling edge of `clk`. A change of `crisp_in` between two falling edges has no effect on `row_sel` or `grade` until the next falling edge.
- R2: Bit i of `row_sel` is 1 exactly when the latched value equals breakpoint i, which is field `BREAKS[8*i +: 8]`. With the default parameters, breakpoint i is 10*i for i = 0 to 10.
- R3: At most one bit of `row_sel` is 1 at any time.
- R4: When `row_sel` bit i is 1, `grade` equals row i, which is field `GRADES[8*i +: 8]`. The default rows for i = 0 to 10 are 0x0A, 0x08, 0x06, 0x04, 0x02, 0x01, 0x03, 0x05, 0x07, 0x09, 0x0B.
- R5: A latched value of 0 gives `row_sel` = 11'b000_0000_0001 and `grade` = 0x0A.
- R6: A latched value of 40 gives `row_sel` with only bit 4 set and `grade` = 0x02.
- R7: A latched value that equals no breakpoint gives `row_sel` = 0 and `grade` = 0x00.
- R8: `rst_n` low clears the latch to 0 at once, without a clock edge, so `row_sel` = 11'b1 and `grade` = 0x0A while reset is held.
- R9: `grade` changes only when the latched value changes, which happens on a falling edge or on reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock. The input is latched on its falling edge. |
| rst_n | input | 1 | Asynchronous reset, active low. |
| crisp_in | input | 8 | Crisp sensor reading. Bit 0 is the LSB. |
| row_sel | output | 11 | One-hot select bus. Bit i means breakpoint i matched. |
| grade | output | 8 | Membership grade taken from the selected row. |

## Verification
The bench builds the block with the default parameters: breakpoints spaced ten apart from 0 to 100, and eleven distinct non-zero grade rows. Because every row is non-zero, a wrong row, a wrong bit order or a missing row shows up in `grade`. It cannot be mistaken for the all-zero result of an unmatched reading. The spacing means random readings mostly miss, so the bench mixes forced breakpoint hits, the values next to each breakpoint, and 255 with the random draws. That keeps hits, near misses and the top of the input range all in reach.

// File: rtl/fuzz_grade_lut.sv
module fuzz_grade_lut #(
  parameter int IN_W    = 8,
  parameter int GRADE_W = 8,
  parameter int ROWS    = 11,
  parameter logic [ROWS*IN_W-1:0] BREAKS = {
    8'd100, 8'd90, 8'd80, 8'd70, 8'd60, 8'd50,
    8'd40,  8'd30, 8'd20, 8'd10, 8'd0},
  parameter logic [ROWS*GRADE_W-1:0] GRADES = {
    8'h0B, 8'h09, 8'h07, 8'h05, 8'h03, 8'h01,
    8'h02, 8'h04, 8'h06, 8'h08, 8'h0A}
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [IN_W-1:0]    crisp_in,
  output logic [ROWS-1:0]    row_sel,
  output logic [GRADE_W-1:0] grade
);

  logic [IN_W-1:0] held_q;

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) held_q <= '0;
    else        held_q <= crisp_in;
  end

  logic [GRADE_W-1:0] acc [ROWS+1];
  assign acc[0] = '0;

  for (genvar i = 0; i < ROWS; i++) begin : g_row
    // Each select line is an AND of the latched bits, true or inverted per pattern bit.
    assign row_sel[i] = &(held_q ~^ BREAKS[i*IN_W +: IN_W]);
    assign acc[i+1]   = acc[i] | ({GRADE_W{row_sel[i]}} & GRADES[i*GRADE_W +: GRADE_W]);
  end

  assign grade = acc[ROWS];

endmodule

module fuzz_grade_lut_chk #(
  parameter int IN_W    = 8,
  parameter int GRADE_W = 8,
  parameter int ROWS    = 11
) (
  input logic               clk,
  input logic               rst_n,
  input logic [IN_W-1:0]    crisp_in,
  input logic [IN_W-1:0]    held,
  input logic [ROWS-1:0]    row_sel,
  input logic [GRADE_W-1:0] grade
);

  p_capture_r1: assert property (@(negedge clk) disable iff (!rst_n)
    $past(rst_n) |-> held == $past(crisp_in));

  p_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(row_sel));

  p_nomatch_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    row_sel == '0 |-> grade == '0);

  p_reset_row0_r8: assert property (@(posedge clk)
    !rst_n |-> row_sel == {{(ROWS-1){1'b0}}, 1'b1});

  p_grade_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(held) |-> $stable(grade));

endmodule

bind fuzz_grade_lut fuzz_grade_lut_chk #(
  .IN_W(IN_W), .GRADE_W(GRADE_W), .ROWS(ROWS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .crisp_in(crisp_in),
  .held(held_q), .row_sel(row_sel), .grade(grade)
);

// File: tb/test_fuzz_grade_lut.sv
module test_fuzz_grade_lut;

  logic        clk = 1'b0;
  logic        rst_n = 1'b1;
  logic [7:0]  crisp_in = 8'd0;
  logic [10:0] row_sel;
  logic [7:0]  grade;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  fuzz_grade_lut i_fuzz_grade_lut (
    .clk(clk), .rst_n(rst_n), .crisp_in(crisp_in),
    .row_sel(row_sel), .grade(grade)
  );

  always #5 clk = ~clk;

  function automatic logic [7:0] row_val(int i);
    case (i)
      0: return 8'h0A;  1: return 8'h08;  2: return 8'h06;  3: return 8'h04;
      4: return 8'h02;  5: return 8'h01;  6: return 8'h03;  7: return 8'h05;
      8: return 8'h07;  9: return 8'h09;  10: return 8'h0B;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [10:0] exp_sel(logic [7:0] v);
    logic [10:0] s = '0;
    for (int i = 0; i < 11; i++) if (int'(v) == 10*i) s[i] = 1'b1;
    return s;
  endfunction

  function automatic logic [7:0] exp_grade(logic [7:0] v);
    for (int i = 0; i < 11; i++) if (int'(v) == 10*i) return row_val(i);
    return 8'h00;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic apply(logic [7:0] v, string req);
    @(posedge clk); #1 crisp_in = v;
    @(negedge clk); #1;
    chk({req, " sel"}, 32'(row_sel), 32'(exp_sel(v)));
    chk({req, " grade"}, 32'(grade), 32'(exp_grade(v)));
  endtask

  initial begin
    #1 rst_n = 1'b0;
    #30;
    chk("R8 reset sel", 32'(row_sel), 32'h001);
    chk("R8 reset grade", 32'(grade), 32'h0A);
    @(posedge clk); #1 rst_n = 1'b1;

    apply(8'd0, "R5");
    apply(8'd40, "R6");
    chk("R6 only bit4", 32'(row_sel), 32'h010);
    apply(8'd41, "R7");
    chk("R7 zero", 32'(grade), 32'h0);
    apply(8'd255, "R7");
    apply(8'd100, "R4");

    for (int i = 0; i < 11; i++) begin
      apply(8'(10*i), "R2");
      chk("R4 row", 32'(grade), 32'(row_val(i)));
      chk("R3 onehot", 32'($countones(row_sel)), 32'd1);
    end

    // R1/R9: input changes between falling edges leave outputs untouched
    apply(8'd30, "R1");
    @(posedge clk); #1 crisp_in = 8'd77;
    #2;
    chk("R1 hold sel", 32'(row_sel), 32'(exp_sel(8'd30)));
    chk("R9 hold grade", 32'(grade), 32'h04);
    @(negedge clk); #1;
    chk("R1 capture", 32'(grade), 32'h00);

    // R8: asynchronous clear between edges
    apply(8'd90, "R2");
    @(posedge clk); #2 rst_n = 1'b0;
    #1;
    chk("R8 async sel", 32'(row_sel), 32'h001);
    chk("R8 async grade", 32'(grade), 32'h0A);
    @(posedge clk); #1 rst_n = 1'b1;

    void'($urandom(32'd2024));
    for (int n = 0; n < 400; n++) begin
      logic [7:0] v;
      case ($urandom % 4)
        0: v = 8'(10 * ($urandom % 11));
        1: v = 8'(10 * ($urandom % 11) + 1);
        2: v = 8'(10 * ($urandom % 11) - 1);
        default: v = 8'($urandom);
      endcase
      apply(v, "R2 rand");
      chk("R3 rand", 32'($countones(row_sel) <= 1), 32'd1);
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule